// File: doc/BRIEF.md
# Justified Stereo Serial Audio Port

This block is the digital edge of a stereo codec: a slave-mode serial port driven from outside by a bit clock and a frame clock. One line carries playback samples into the chip and another carries record samples out. Each frame holds a left-channel half and then a right-channel half. The frame clock is high for the left half and low for the right half.

On the playback side the block collects 16-bit words that sit at the end of each half-frame, MSB first. They are right-justified, so the LSB is the last bit before the frame clock toggles. Any bits before that word are padding. The block returns each completed left/right pair as two parallel words together with a one-cycle valid strobe. On the record side it takes a parallel pair, latches it at the start of every left half, and shifts each word out MSB first from the first bit of its half (left-justified). It drives zeros for the rest of the half. The port works with 32, 48 or 64 bit clocks per frame and needs no setting to do so.

All logic runs on the system clock. The three serial pins pass through two-flop synchronizers, and the bit-clock edges are found from the synchronized level.

Top module: `serial_audio_port`

## Requirements
- R1: While reset is high and right after it, rx_left_o, rx_right_o, rx_valid_o, tx_accept_o and sdo_o are all 0.
- R2: rx_left_o is the last 16 bits sampled on bit-clock rising edges while the frame clock was high (1 = left), first sampled bit in bit 15.
- R3: rx_right_o is the last 16 bits sampled on bit-clock rising edges while the frame clock was low (0 = right), first sampled bit in bit 15.
- R4: rx_valid_o is a single-cycle pulse, one per frame, on the first bit-clock rising edge of a left half. It appears only once the right half before it and the left half before that both began at an observed frame-clock toggle, so no pulse comes before the end of the first full frame after reset. The two words change only together with that pulse.
- R5: Padding bits that come before the last 16 bits of a half do not reach either received word.
- R6: From the first bit of a left half, sdo_o carries the latched left word MSB first, one bit per bit-clock period, and changes only after a bit-clock falling edge.
- R7: From the first bit of a right half, sdo_o carries the latched right word MSB first.
- R8: In a half longer than 16 bits, sdo_o is 0 for every bit after the 16th.
- R9: tx_left_i and tx_right_i are latched together at the first bit-clock falling edge of each left half, marked by a single-cycle tx_accept_o pulse. Changes to them later in the frame do not affect that frame.
- R10: Halves of 16, 24 and 32 bit clocks (frames of 32, 48 and 64) all work with no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_i | input | 1 | Serial bit clock (asynchronous) |
| frm_i | input | 1 | Frame clock, 1 = left half, 0 = right half (asynchronous) |
| sdi_i | input | 1 | Playback serial data, right-justified |
| sdo_o | output | 1 | Record serial data, left-justified |
| rx_left_o | output | 16 | Last received left word |
| rx_right_o | output | 16 | Last received right word |
| rx_valid_o | output | 1 | Pulse: a new received pair is on the word outputs |
| tx_left_i | input | 16 | Left word to transmit |
| tx_right_i | input | 16 | Right word to transmit |
| tx_accept_o | output | 1 | Pulse: the transmit pair was latched |

## Verification
The bench cycles through all three frame lengths with several word patterns: all ones against all zeros, words with only the end bits set, and arithmetic sequences. These show whether the bit order or the channel is swapped. Each padded frame carries padding that is the complement of the real word, so a receive window that is off by even one bit gives a wrong word. In one frame the transmit inputs are changed in the middle, which separates latching at the start of the left half from sampling the inputs live. The first frame after reset checks that no early valid pulse appears.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;
  // frame clock level that marks the left half
  localparam logic LEFT_LVL = 1'b1;

  // serial pins in synchronizer order
  typedef struct packed {
    logic bck;
    logic frm;
    logic sdi;
  } pins_t;
endpackage

// File: rtl/sap_sync.sv
`timescale 1ns/1ps
module sap_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[s] <= '0;
          else     pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/sap_edge.sv
`timescale 1ns/1ps
module sap_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;
endmodule

// File: rtl/sap_rx.sv
`timescale 1ns/1ps
module sap_rx
  import sap_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             frm_i,
  input  logic             sdi_i,
  output logic [WIDTH-1:0] left_o,
  output logic [WIDTH-1:0] right_o,
  output logic             valid_o
);
  // sliding window: always holds the latest WIDTH bits
  logic [WIDTH-1:0] win_q;
  logic [WIDTH-1:0] hold_left_q;
  logic             frm_prev_q;
  logic [1:0]       bnd_cnt_q;
  logic             toggle;

  assign toggle = rise_i && (frm_i != frm_prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q       <= '0;
      hold_left_q <= '0;
      frm_prev_q  <= 1'b0;
      bnd_cnt_q   <= 2'd0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise_i) begin
        win_q      <= {win_q[WIDTH-2:0], sdi_i};
        frm_prev_q <= frm_i;
      end
      if (toggle) begin
        if (bnd_cnt_q != 2'd2) bnd_cnt_q <= bnd_cnt_q + 2'd1;
        if (frm_prev_q == LEFT_LVL) begin
          hold_left_q <= win_q;
        end else if (bnd_cnt_q == 2'd2) begin
          left_o  <= hold_left_q;
          right_o <= win_q;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sap_tx.sv
`timescale 1ns/1ps
module sap_tx
  import sap_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall_i,
  input  logic             frm_i,
  input  logic [WIDTH-1:0] tx_left_i,
  input  logic [WIDTH-1:0] tx_right_i,
  output logic             sdo_o,
  output logic             accept_o
);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [IDX_W-1:0] IDX_WORD = IDX_W'(WIDTH);

  logic [WIDTH-1:0] word_l_q, word_r_q;
  logic [IDX_W-1:0] idx_q;
  logic             frm_last_q;
  logic             primed_q;
  logic [WIDTH-1:0] cur_word, shifted;

  always_comb begin
    cur_word = (frm_i == LEFT_LVL) ? word_l_q : word_r_q;
    shifted  = cur_word << idx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_l_q   <= '0;
      word_r_q   <= '0;
      idx_q      <= '0;
      frm_last_q <= 1'b0;
      primed_q   <= 1'b0;
      sdo_o      <= 1'b0;
      accept_o   <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      if (fall_i) begin
        frm_last_q <= frm_i;
        if (frm_i != frm_last_q) begin
          primed_q <= 1'b1;
          idx_q    <= IDX_W'(1);
          if (frm_i == LEFT_LVL) begin
            word_l_q <= tx_left_i;
            word_r_q <= tx_right_i;
            accept_o <= 1'b1;
            sdo_o    <= tx_left_i[WIDTH-1];
          end else begin
            sdo_o <= word_r_q[WIDTH-1];
          end
        end else begin
          if (idx_q != IDX_MAX) idx_q <= idx_q + IDX_W'(1);
          sdo_o <= primed_q && (idx_q < IDX_WORD) && shifted[WIDTH-1];
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_port.sv
`timescale 1ns/1ps
module serial_audio_port
  import sap_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int MAX_HALF    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bck_i,
  input  logic             frm_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic [WIDTH-1:0] rx_left_o,
  output logic [WIDTH-1:0] rx_right_o,
  output logic             rx_valid_o,
  input  logic [WIDTH-1:0] tx_left_i,
  input  logic [WIDTH-1:0] tx_right_i,
  output logic             tx_accept_o
);
  localparam int IDX_W  = $clog2(MAX_HALF) + 1;
  localparam int PIN_W  = $bits(pins_t);

  pins_t raw_pins, sync_pins;
  logic  bck_rise, bck_fall;

  assign raw_pins = '{bck: bck_i, frm: frm_i, sdi: sdi_i};

  sap_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_pins),
    .q_o (sync_pins)
  );

  sap_edge u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (sync_pins.bck),
    .rise_o (bck_rise),
    .fall_o (bck_fall)
  );

  sap_rx #(.WIDTH(WIDTH)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (bck_rise),
    .frm_i   (sync_pins.frm),
    .sdi_i   (sync_pins.sdi),
    .left_o  (rx_left_o),
    .right_o (rx_right_o),
    .valid_o (rx_valid_o)
  );

  sap_tx #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (bck_fall),
    .frm_i      (sync_pins.frm),
    .tx_left_i  (tx_left_i),
    .tx_right_i (tx_right_i),
    .sdo_o      (sdo_o),
    .accept_o   (tx_accept_o)
  );
endmodule

// File: rtl/sap_port_chk.sv
`timescale 1ns/1ps
module sap_port_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             bck_rise,
  input logic             bck_fall,
  input logic             sdo_o,
  input logic             rx_valid_o,
  input logic             tx_accept_o,
  input logic [WIDTH-1:0] rx_left_o,
  input logic [WIDTH-1:0] rx_right_o
);
  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o);

  a_r4_valid_on_rise: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> $past(bck_rise));

  a_r4_words_hold: assert property (@(posedge clk) disable iff (rst)
    !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o)));

  a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo_o) |-> $past(bck_fall));

  a_r9_accept_single: assert property (@(posedge clk) disable iff (rst)
    tx_accept_o |=> !tx_accept_o);

  a_r9_accept_on_fall: assert property (@(posedge clk) disable iff (rst)
    tx_accept_o |-> $past(bck_fall));
endmodule

bind serial_audio_port sap_port_chk #(.WIDTH(WIDTH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bck_rise    (bck_rise),
  .bck_fall    (bck_fall),
  .sdo_o       (sdo_o),
  .rx_valid_o  (rx_valid_o),
  .tx_accept_o (tx_accept_o),
  .rx_left_o   (rx_left_o),
  .rx_right_o  (rx_right_o)
);

// File: tb/serial_audio_port_tb_top.sv
`timescale 1ns/1ps
module serial_audio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bck = 1'b1;
  logic        frm = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo;
  logic [15:0] rx_l, rx_r, tx_l, tx_r;
  logic        rx_v, tx_acc;

  int total = 0;
  int bad   = 0;
  int vcount = 0;
  int acount = 0;
  logic [15:0] got_l = 16'h0, got_r = 16'h0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  serial_audio_port dut_i (
    .clk(clk), .rst(rst), .bck_i(bck), .frm_i(frm), .sdi_i(sdi),
    .sdo_o(sdo), .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_v),
    .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_accept_o(tx_acc)
  );

  always @(negedge clk) begin
    if (!rst && rx_v) begin
      vcount = vcount + 1;
      got_l  = rx_l;
      got_r  = rx_r;
    end
    if (!rst && tx_acc) acount = acount + 1;
  end

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one half-frame: n bits, padding g ahead of word w; captures sdo per bit
  task automatic send_half(input int n, input logic ch, input logic [15:0] w,
                           input logic [15:0] g, output logic [31:0] cap);
    logic [31:0] full;
    full = {g, w};
    cap  = 32'h0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bck = 1'b0;
      frm = ch;
      sdi = full[n-1-i];
      repeat (8) @(negedge clk);
      cap = {cap[30:0], sdo};
      bck = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  initial begin
    logic [31:0] cap_l, cap_r;
    logic [15:0] exp_tl, exp_tr, prev_l, prev_r;
    logic [15:0] rl, rr;
    int n, a0;
    tx_l = 16'h0;
    tx_r = 16'h0;
    prev_l = 16'h0;
    prev_r = 16'h0;
    repeat (4) @(negedge clk);
    // R1: reset values while reset is applied and just after release
    check(rx_l == 16'h0 && rx_r == 16'h0, "R1 words in reset", {rx_l, rx_r}, 32'h0);
    check(!rx_v && !tx_acc && !sdo, "R1 strobes in reset", {29'h0, rx_v, tx_acc, sdo}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!rx_v && !tx_acc && !sdo && rx_l == 16'h0, "R1 after release",
          {rx_l, 13'h0, rx_v, tx_acc, sdo}, 32'h0);

    for (int f = 0; f < 13; f++) begin
      n  = (f % 3 == 0) ? 16 : ((f % 3 == 1) ? 24 : 32);
      rl = 16'(f * 16'h1357) ^ 16'hA5C3;
      rr = 16'(f * 16'h0F1D) ^ 16'h3C69;
      if (f == 1) begin rl = 16'hFFFF; rr = 16'h0000; end
      if (f == 2) begin rl = 16'h8001; rr = 16'h7FFE; end
      if (f != 5) begin
        tx_l = 16'(f * 16'h2468) ^ 16'h0F0F;
        tx_r = 16'(f * 16'h1111) ^ 16'hC3A5;
      end
      exp_tl = tx_l;
      exp_tr = tx_r;
      a0 = acount;
      send_half(n, 1'b1, rl, ~rl, cap_l);
      if (f == 4) begin
        tx_l = 16'hDEAD;
        tx_r = 16'hBEEF;
      end
      send_half(n, 1'b0, rr, ~rr, cap_r);
      // R6/R7/R8/R10: MSB-first word then zeros, for this frame length
      check(cap_l == ({16'h0, exp_tl} << (n - 16)), "R6 R8 R10 tx left half",
            cap_l, {16'h0, exp_tl} << (n - 16));
      check(cap_r == ({16'h0, exp_tr} << (n - 16)), "R7 R8 R10 tx right half",
            cap_r, {16'h0, exp_tr} << (n - 16));
      // R9: exactly one latch per frame
      check(acount == a0 + 1, "R9 one accept per frame", 32'(acount - a0), 32'd1);
      // R4: pairs reported so far equal frames fully completed before this one
      check(vcount == f, "R4 valid count", 32'(vcount), 32'(f));
      if (f > 0) begin
        // R2/R3/R5/R10: previous frame's words, padding excluded
        check(got_l == prev_l, "R2 R5 R10 rx left word", {16'h0, got_l}, {16'h0, prev_l});
        check(got_r == prev_r, "R3 R5 R10 rx right word", {16'h0, got_r}, {16'h0, prev_r});
      end
      prev_l = rl;
      prev_r = rr;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule